// File: doc/BRIEF.md
# Dual Compare-and-Swap Execution Unit

This unit carries out a two-location atomic compare-and-swap for a processor core. When started, it takes an opcode and two extension words. Each extension word names three registers: a base register that holds an operand address, an update register and a compare register. The unit collects those register values through a single sixteen-entry register-file read port. It then fetches both memory operands at the operand size selected by the opcode, while holding a bus lock.

It compares each memory operand with its compare register, using only the bits covered by the operand size. If both pairs match, the two update values go to memory, first location first. If either pair differs, memory is left alone. In that case both memory operands are loaded into their compare registers through a data-register write port, and the register bits above the operand size are kept. Condition flags follow subtract-compare semantics. The second pair can override the flags only when the first pair matched.

The core uses the unit as a multi-cycle execution resource. It raises `start` for one cycle while idle, waits for `done`, and charges the instruction the fixed cost shown on `op_cycles`.

Top module: `dcas_unit`

## Requirements
- R1: Each extension word is decoded as base register in bits 15..12, update register in bits 8..6 and compare register in bits 2..0. All other bits are ignored.
- R2: A base field of 8..15 reads register-file entry 8..15 (the address registers). A base field of 0..7 reads data register 0..7, and that value is used as the operand address.
- R3: Opcode bits 11..9 select the size: 101 byte, 110 word, 111 long, and every other value long. `mem_size` shows it as 0 byte, 1 word, 2 long.
- R4: Both memory reads, first operand then second, finish before any memory write. `mem_lock` is high on every memory request, from the first read through the last write.
- R5: Flags {N,Z,V,C} are written once per operation. They come from compare-register minus first memory operand, unless the first pair matched. In that case they come from the second pair's subtraction.
- R6: When both masked pairs match, the first update value (masked to size) is written to the first address, then the second update value to the second address. No register is written.
- R7: When either pair differs, no memory write occurs. The first compare register and then the second are loaded with their memory operands. Bits above a byte or word operand keep their old value.
- R8: If both compare fields name the same register on a mismatch, that register ends holding the second memory operand.
- R9: `op_cycles` always reports 40.
- R10: `done` is a single-cycle pulse that follows the last write-back. `busy` is high from the cycle after `start` until `done`, and falls right after it.
- R11: After reset the unit is idle: `busy`, `done`, `mem_req`, `mem_lock`, `rf_we` and `flag_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| opcode | input | 16 | Instruction word; bits 11..9 carry the size |
| ext_a | input | 16 | Extension word for the first operand |
| ext_b | input | 16 | Extension word for the second operand |
| rf_raddr | output | 4 | Register-file read index (0..7 data, 8..15 address) |
| rf_rdata | input | 32 | Register-file read data, same cycle |
| rf_we | output | 1 | Data-register write strobe |
| rf_waddr | output | 3 | Data-register write index |
| rf_wdata | output | 32 | Data-register write value |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Bus lock for the read-modify-write window |
| mem_size | output | 2 | Access size: 0 byte, 1 word, 2 long |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, right-aligned, valid with `mem_ack` |
| flag_we | output | 1 | Flag update strobe |
| flags | output | 4 | {N,Z,V,C} value for the update |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| op_cycles | output | 8 | Reported instruction cost |

## Verification
Both pair comparisons are resolved in one evaluation cycle, and that same cycle fixes both the flag value and the choice between the swap and the reload. The bench sets up cases where the pairs disagree in each direction. In one, the first pair differs while the second matches. In another, the first matches while the second differs, and there the two subtractions give flag values that can be told apart. Each run is judged by which flag value was written and which write path followed. A second collision happens when both reload writes target the same register. The bench forces it by naming one compare register twice, and then checks that the register holds the second memory operand.

// File: rtl/dcas_pkg.sv
package dcas_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } opsize_e;

    typedef enum logic [3:0] {
        PH_IDLE = 4'd0,
        PH_ADR  = 4'd1,
        PH_CREG = 4'd2,
        PH_UREG = 4'd3,
        PH_MRD  = 4'd4,
        PH_EVAL = 4'd5,
        PH_MWR  = 4'd6,
        PH_WB   = 4'd7,
        PH_DONE = 4'd8
    } phase_e;

    typedef struct packed {
        logic [3:0] base;
        logic [2:0] upd;
        logic [2:0] cmp;
    } slot_t;

    function automatic logic [WORD_W-1:0] size_mask(opsize_e s);
        case (s)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_WORD: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int unsigned size_msb(opsize_e s);
        case (s)
            SZ_BYTE: size_msb = 7;
            SZ_WORD: size_msb = 15;
            default: size_msb = 31;
        endcase
    endfunction

endpackage

// File: rtl/dcas_decode.sv
module dcas_decode
    import dcas_pkg::*;
#(
    parameter int unsigned SLOTS = 2
) (
    input  logic [2:0]              size_field,
    input  logic [SLOTS-1:0][3:0]   base_f,
    input  logic [SLOTS-1:0][2:0]   upd_f,
    input  logic [SLOTS-1:0][2:0]   cmp_f,
    output opsize_e                 size,
    output slot_t [SLOTS-1:0]       slot
);

    always_comb begin
        case (size_field)
            3'b101:  size = SZ_BYTE;
            3'b110:  size = SZ_WORD;
            default: size = SZ_LONG;
        endcase
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot[g].base = base_f[g];
        assign slot[g].upd  = upd_f[g];
        assign slot[g].cmp  = cmp_f[g];
    end

endmodule

// File: rtl/dcas_compare.sv
module dcas_compare
    import dcas_pkg::*;
(
    input  opsize_e             size,
    input  logic [WORD_W-1:0]   lhs,
    input  logic [WORD_W-1:0]   rhs,
    output logic                eq,
    output logic [3:0]          nzvc
);

    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] diff;
    int unsigned       top;

    always_comb begin
        mask = size_mask(size);
        top  = size_msb(size);
        a    = lhs & mask;
        b    = rhs & mask;
        diff = (a - b) & mask;
        eq   = (a == b);
        nzvc[3] = diff[top];
        nzvc[2] = (diff == '0);
        nzvc[1] = (a[top] != b[top]) && (diff[top] != a[top]);
        nzvc[0] = (b > a);
    end

endmodule

// File: rtl/dcas_merge.sv
module dcas_merge
    import dcas_pkg::*;
(
    input  opsize_e             size,
    input  logic [WORD_W-1:0]   keep,
    input  logic [WORD_W-1:0]   load,
    output logic [WORD_W-1:0]   merged
);

    logic [WORD_W-1:0] mask;

    always_comb begin
        mask   = size_mask(size);
        merged = (keep & ~mask) | (load & mask);
    end

endmodule

// File: rtl/dcas_unit.sv
module dcas_unit
    import dcas_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned RF_ENTRIES = 16,
    parameter int unsigned CYCLE_COST = 40,
    parameter int unsigned COST_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [15:0]                   opcode,
    input  logic [15:0]                   ext_a,
    input  logic [15:0]                   ext_b,
    output logic [$clog2(RF_ENTRIES)-1:0] rf_raddr,
    input  logic [31:0]                   rf_rdata,
    output logic                          rf_we,
    output logic [2:0]                    rf_waddr,
    output logic [31:0]                   rf_wdata,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic                          mem_lock,
    output logic [1:0]                    mem_size,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [31:0]                   mem_wdata,
    input  logic                          mem_ack,
    input  logic [31:0]                   mem_rdata,
    output logic                          flag_we,
    output logic [3:0]                    flags,
    output logic                          busy,
    output logic                          done,
    output logic [COST_W-1:0]             op_cycles
);

    localparam int unsigned RFAW  = $clog2(RF_ENTRIES);
    localparam int unsigned SLOTS = 2;

    typedef struct packed {
        phase_e                              phase;
        logic                                sel;
        opsize_e                             size;
        slot_t [SLOTS-1:0]                   slot;
        logic [SLOTS-1:0][ADDR_W-1:0]        addr;
        logic [SLOTS-1:0][WORD_W-1:0]        cval;
        logic [SLOTS-1:0][WORD_W-1:0]        uval;
        logic [SLOTS-1:0][WORD_W-1:0]        mval;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    opsize_e               dec_size;
    slot_t [SLOTS-1:0]     dec_slot;
    logic  [SLOTS-1:0]     cmp_eq;
    logic  [SLOTS-1:0][3:0] cmp_flags;
    logic  [SLOTS-1:0][WORD_W-1:0] reload;
    logic  [WORD_W-1:0]    cur_mask;

    dcas_decode #(.SLOTS(SLOTS)) u_decode (
        .size_field (opcode[11:9]),
        .base_f     ({ext_b[15:12], ext_a[15:12]}),
        .upd_f      ({ext_b[8:6],   ext_a[8:6]}),
        .cmp_f      ({ext_b[2:0],   ext_a[2:0]}),
        .size       (dec_size),
        .slot       (dec_slot)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_pair
        dcas_compare u_cmp (
            .size   (ctx_q.size),
            .lhs    (ctx_q.cval[g]),
            .rhs    (ctx_q.mval[g]),
            .eq     (cmp_eq[g]),
            .nzvc   (cmp_flags[g])
        );
        dcas_merge u_merge (
            .size   (ctx_q.size),
            .keep   (ctx_q.cval[g]),
            .load   (ctx_q.mval[g]),
            .merged (reload[g])
        );
    end

    assign cur_mask  = size_mask(ctx_q.size);
    assign op_cycles = COST_W'(CYCLE_COST);
    assign mem_size  = ctx_q.size;
    assign busy      = (ctx_q.phase != PH_IDLE);

    always_comb begin
        ctx_d     = ctx_q;
        rf_raddr  = '0;
        rf_we     = 1'b0;
        rf_waddr  = '0;
        rf_wdata  = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_lock  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        flag_we   = 1'b0;
        flags     = '0;
        done      = 1'b0;

        case (ctx_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctx_d.size  = dec_size;
                    ctx_d.slot  = dec_slot;
                    ctx_d.sel   = 1'b0;
                    ctx_d.phase = PH_ADR;
                end
            end
            PH_ADR: begin
                rf_raddr = RFAW'(ctx_q.slot[ctx_q.sel].base);
                ctx_d.addr[ctx_q.sel] = rf_rdata[ADDR_W-1:0];
                ctx_d.sel = ~ctx_q.sel;
                if (ctx_q.sel) ctx_d.phase = PH_CREG;
            end
            PH_CREG: begin
                rf_raddr = RFAW'(ctx_q.slot[ctx_q.sel].cmp);
                ctx_d.cval[ctx_q.sel] = rf_rdata;
                ctx_d.sel = ~ctx_q.sel;
                if (ctx_q.sel) ctx_d.phase = PH_UREG;
            end
            PH_UREG: begin
                rf_raddr = RFAW'(ctx_q.slot[ctx_q.sel].upd);
                ctx_d.uval[ctx_q.sel] = rf_rdata;
                ctx_d.sel = ~ctx_q.sel;
                if (ctx_q.sel) ctx_d.phase = PH_MRD;
            end
            PH_MRD: begin
                mem_req  = 1'b1;
                mem_lock = 1'b1;
                mem_addr = ctx_q.addr[ctx_q.sel];
                if (mem_ack) begin
                    ctx_d.mval[ctx_q.sel] = mem_rdata & cur_mask;
                    ctx_d.sel = ~ctx_q.sel;
                    if (ctx_q.sel) ctx_d.phase = PH_EVAL;
                end
            end
            PH_EVAL: begin
                mem_lock = 1'b1;
                flag_we  = 1'b1;
                flags    = cmp_eq[0] ? cmp_flags[1] : cmp_flags[0];
                ctx_d.sel   = 1'b0;
                ctx_d.phase = (&cmp_eq) ? PH_MWR : PH_WB;
            end
            PH_MWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_lock  = 1'b1;
                mem_addr  = ctx_q.addr[ctx_q.sel];
                mem_wdata = ctx_q.uval[ctx_q.sel] & cur_mask;
                if (mem_ack) begin
                    ctx_d.sel = ~ctx_q.sel;
                    if (ctx_q.sel) ctx_d.phase = PH_DONE;
                end
            end
            PH_WB: begin
                rf_we    = 1'b1;
                rf_waddr = ctx_q.slot[ctx_q.sel].cmp;
                rf_wdata = reload[ctx_q.sel];
                ctx_d.sel = ~ctx_q.sel;
                if (ctx_q.sel) ctx_d.phase = PH_DONE;
            end
            PH_DONE: begin
                done        = 1'b1;
                ctx_d.phase = PH_IDLE;
            end
            default: ctx_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

endmodule

// File: rtl/dcas_unit_checker.sv
module dcas_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_lock,
    input logic [1:0] mem_size,
    input logic       rf_we,
    input logic       flag_we
);

    // R4: every memory access sits inside the lock window
    assert_req_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R3: operand size cannot change inside a locked window
    assert_size_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && $past(mem_lock)) |-> $stable(mem_size));

    // R5: the flag update is followed at once by a commit or a reload
    assert_flags_then_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (mem_req || rf_we));

    // R6: a successful swap never writes a register at the same time
    assert_no_mixed_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && rf_we));

    // R7: register reloads only happen outside the lock window
    assert_reload_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !mem_lock);

    // R10: completion is a single pulse and ends the busy period
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

bind dcas_unit dcas_unit_checker u_dcas_unit_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_lock (mem_lock),
    .mem_size (mem_size),
    .rf_we    (rf_we),
    .flag_we  (flag_we)
);

// File: tb/dcas_unit_bench.sv
module dcas_unit_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] ext_a = '0;
    logic [15:0] ext_b = '0;
    logic [3:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mem_req, mem_we, mem_lock;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        flag_we;
    logic [3:0]  flags;
    logic        busy, done;
    logic [7:0]  op_cycles;

    logic [31:0] rf [16];
    logic [7:0]  mem [256];

    int n_cmp = 0;
    int n_bad = 0;
    int wr_n, rd_n, rfw_n, flag_n, done_n, lock_err, order_err;
    logic [31:0] wr_log [4];
    logic [3:0]  flag_val;
    logic [1:0]  last_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata = rf[rf_raddr];

    dcas_unit u_dcas_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .ext_a(ext_a), .ext_b(ext_b),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .flag_we(flag_we), .flags(flags), .busy(busy), .done(done),
        .op_cycles(op_cycles)
    );

    function automatic logic [15:0] mk(input logic [3:0] rn, input logic [2:0] du, input logic [2:0] dc);
        mk = {rn, 3'b000, du, 3'b000, dc};
    endfunction

    function automatic logic [31:0] get32(input logic [7:0] a);
        get32 = {mem[a], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
    endfunction

    task automatic put32(input logic [7:0] a, input logic [31:0] v);
        mem[a] = v[31:24]; mem[8'(a+1)] = v[23:16];
        mem[8'(a+2)] = v[15:8]; mem[8'(a+3)] = v[7:0];
    endtask

    // memory and register-file model, serviced away from the active edge
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            logic [7:0] a;
            a = mem_addr[7:0];
            last_size = mem_size;
            if (!mem_lock) lock_err++;
            if (mem_we) begin
                case (mem_size)
                    2'd0: mem[a] = mem_wdata[7:0];
                    2'd1: begin mem[a] = mem_wdata[15:8]; mem[8'(a+1)] = mem_wdata[7:0]; end
                    default: put32(a, mem_wdata);
                endcase
                if (wr_n < 4) wr_log[wr_n] = mem_addr;
                wr_n++;
            end else begin
                case (mem_size)
                    2'd0: mem_rdata = {24'h0, mem[a]};
                    2'd1: mem_rdata = {16'h0, mem[a], mem[8'(a+1)]};
                    default: mem_rdata = get32(a);
                endcase
                if (wr_n != 0) order_err++;
                rd_n++;
            end
            mem_ack = 1'b1;
        end else begin
            mem_ack = 1'b0;
        end
        if (rf_we) begin
            rf[{1'b0, rf_waddr}] = rf_wdata;
            rfw_n++;
        end
        if (flag_we) begin
            flag_val = flags;
            flag_n++;
        end
        if (done) done_n++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_state();
        for (int i = 0; i < 16; i++) rf[i] = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic run_op(input logic [15:0] op, input logic [15:0] ea, input logic [15:0] eb);
        wr_n = 0; rd_n = 0; rfw_n = 0; flag_n = 0; done_n = 0;
        lock_err = 0; order_err = 0; flag_val = 4'hx;
        @(negedge clk);
        opcode = op; ext_a = ea; ext_b = eb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start", 32'(busy), 32'd1);
        for (int i = 0; i < 300 && done_n == 0; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R10 single done pulse", done_n, 1);
        chk("R10 busy cleared", 32'(busy), 32'd0);
        chk("R4 lock on every access", lock_err, 0);
        chk("R4 reads before writes", order_err, 0);
        chk("R5 one flag update", flag_n, 1);
    endtask

    task automatic t_reset();
        chk("R11 busy", 32'(busy), 0);
        chk("R11 done", 32'(done), 0);
        chk("R11 mem_req", 32'(mem_req), 0);
        chk("R11 mem_lock", 32'(mem_lock), 0);
        chk("R11 rf_we", 32'(rf_we), 0);
        chk("R11 flag_we", 32'(flag_we), 0);
        chk("R9 cost", 32'(op_cycles), 32'd40);
    endtask

    task automatic t_long_success();
        clear_state();
        rf[10] = 32'h10; rf[15] = 32'h20;
        rf[6] = 32'hDEADBEEF; rf[7] = 32'h01020304;
        rf[5] = 32'hCAFEF00D; rf[3] = 32'h12345678;
        put32(8'h10, 32'hDEADBEEF); put32(8'h20, 32'h01020304);
        run_op(16'h0EFC, mk(4'd10, 3'd5, 3'd6) | 16'h0E38, mk(4'd15, 3'd3, 3'd7));
        chk("R6 first location", get32(8'h10), 32'hCAFEF00D);
        chk("R6 second location", get32(8'h20), 32'h12345678);
        chk("R6 write count", wr_n, 2);
        chk("R6 first write address", wr_log[0], 32'h10);
        chk("R6 second write address", wr_log[1], 32'h20);
        chk("R4 two reads", rd_n, 2);
        chk("R6 no register write", rfw_n, 0);
        chk("R5 success flags", 32'(flag_val), 32'h4);
        chk("R1 compare reg untouched", rf[6], 32'hDEADBEEF);
        chk("R3 long size", 32'(last_size), 2);
    endtask

    task automatic t_first_mismatch();
        clear_state();
        rf[8] = 32'h30; rf[9] = 32'h40;
        rf[1] = 32'd5; rf[2] = 32'd9;
        put32(8'h30, 32'd7); put32(8'h40, 32'd3);
        run_op(16'h0EFC, mk(4'd8, 3'd3, 3'd1), mk(4'd9, 3'd4, 3'd2));
        chk("R5 flags from first pair", 32'(flag_val), 32'h9);
        chk("R7 first reload", rf[1], 32'd7);
        chk("R7 second reload", rf[2], 32'd3);
        chk("R7 no memory write", wr_n, 0);
        chk("R7 memory kept", get32(8'h30), 32'd7);
        chk("R7 two register writes", rfw_n, 2);
    endtask

    task automatic t_second_mismatch_word();
        clear_state();
        rf[11] = 32'h50; rf[12] = 32'h60;
        rf[1] = 32'hAAAA1234; rf[2] = 32'hBBBB0003;
        mem[8'h50] = 8'h12; mem[8'h51] = 8'h34;
        mem[8'h60] = 8'h00; mem[8'h61] = 8'h09;
        run_op(16'h0CFC, mk(4'd11, 3'd3, 3'd1), mk(4'd12, 3'd4, 3'd2));
        chk("R5 flags from second pair", 32'(flag_val), 32'h9);
        chk("R7 word reload keeps upper", rf[1], 32'hAAAA1234);
        chk("R7 word reload second", rf[2], 32'hBBBB0009);
        chk("R7 no memory write", wr_n, 0);
        chk("R3 word size", 32'(last_size), 1);
    endtask

    task automatic t_byte_success_dreg();
        clear_state();
        rf[0] = 32'h70; rf[1] = 32'h74;
        rf[2] = 32'hFFFFFF5A; rf[3] = 32'h000000C3;
        rf[4] = 32'h111111A5; rf[5] = 32'h2222223C;
        mem[8'h70] = 8'h5A; mem[8'h71] = 8'h99;
        mem[8'h74] = 8'hC3; mem[8'h75] = 8'h88;
        run_op(16'h0AFC, mk(4'd0, 3'd4, 3'd2), mk(4'd1, 3'd5, 3'd3));
        chk("R2 byte via data reg first", 32'(mem[8'h70]), 32'hA5);
        chk("R2 byte via data reg second", 32'(mem[8'h74]), 32'h3C);
        chk("R3 neighbour byte kept", 32'(mem[8'h71]), 32'h99);
        chk("R3 neighbour byte kept 2", 32'(mem[8'h75]), 32'h88);
        chk("R3 byte size", 32'(last_size), 0);
        chk("R5 byte success flags", 32'(flag_val), 32'h4);
        chk("R6 byte write count", wr_n, 2);
    endtask

    task automatic t_same_compare_reg();
        clear_state();
        rf[13] = 32'h80; rf[14] = 32'h90;
        put32(8'h80, 32'h11111111); put32(8'h90, 32'h22222222);
        run_op(16'h0EFC, mk(4'd13, 3'd1, 3'd0), mk(4'd14, 3'd1, 3'd0));
        chk("R8 second operand wins", rf[0], 32'h22222222);
        chk("R8 both writes issued", rfw_n, 2);
    endtask

    task automatic t_default_size();
        clear_state();
        rf[8] = 32'hA0; rf[9] = 32'hB0;
        rf[1] = 32'h80000000; rf[2] = 32'h55;
        put32(8'hA0, 32'h00000001); put32(8'hB0, 32'h55);
        run_op(16'h00FC, mk(4'd8, 3'd3, 3'd1), mk(4'd9, 3'd4, 3'd2));
        chk("R3 default long size", 32'(last_size), 2);
        chk("R5 overflow flag", 32'(flag_val), 32'h2);
        chk("R3 full long reload", rf[1], 32'h00000001);
        chk("R7 second reload", rf[2], 32'h55);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        clear_state();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_success();
        t_first_mismatch();
        t_second_mismatch_word();
        t_byte_success_dreg();
        t_same_compare_reg();
        t_default_size();
        summary();
        $finish;
    end

endmodule